// File: doc/BRIEF.md
# Accumulator Processor Core with Sequenced Control

This block is a small processor core built around one accumulator. Every instruction word is seven bits wide: a three-bit operation code sits above a four-bit immediate operand. A control state machine steps through three phases for each instruction. The fetch phase captures the word from an input port into an instruction register. The decode phase picks the execute state that belongs to the operation code. The execute phase writes the accumulator and then returns to fetch.

The operations are load, add, subtract, increment, decrement, AND, OR and XOR. An internal ALU computes the arithmetic and logic results. A carry/borrow flag records the overflow of the four arithmetic operations. Instruction words arrive on a port that an outside agent drives directly, so no program memory is needed. A one-cycle completion pulse marks the moment the result of each instruction becomes visible.

Top module: `acc_core`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, a clock edge clears the accumulator, the carry flag, the instruction register and `done`, and puts the control in its fetch phase.
- R2: The instruction word is split as opcode = bits [6:4] and immediate = bits [3:0]. The word on `instr_in` is captured only at the edge that ends the fetch phase, so changes to `instr_in` in any other phase have no effect.
- R3: The accumulator and the carry flag change only at the edge that ends an execute phase. During decode and execute they keep their previous values.
- R4: Opcode 000 (load) sets the accumulator to the immediate.
- R5: Opcode 001 (add) sets the accumulator to (accumulator + immediate) mod 16. The carry flag becomes 1 exactly when the true sum exceeds 15.
- R6: Opcode 010 (subtract) sets the accumulator to (accumulator − immediate) mod 16. The carry flag becomes 1 exactly when the accumulator is less than the immediate (borrow).
- R7: Opcode 011 (increment) adds 1 and opcode 100 (decrement) subtracts 1, modulo 16. The immediate bits are ignored. The carry flag becomes 1 on increment from 15, or on decrement from 0.
- R8: Opcodes 101, 110 and 111 set the accumulator to accumulator AND, OR and XOR the immediate, respectively.
- R9: Load and the three logic operations leave the carry flag unchanged.
- R10: Each instruction takes exactly three clock edges after its word is presented in fetch. `done` is high for exactly one cycle, starting at the third edge. The new accumulator value appears at that same edge, and the fetch of the next instruction takes place at the edge that ends the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_in | input | 7 | Instruction word: opcode [6:4], immediate [3:0] |
| acc_out | output | 4 | Current accumulator value |
| carry_out | output | 1 | Carry/borrow flag from the last arithmetic operation |
| done | output | 1 | One-cycle pulse when an instruction completes |

## Verification
The bench builds the core with the default four-bit data width. At that width, every immediate value can be paired with every opcode after a seeded load in under a thousand cycles. This makes the wrap points (15+1, 0−1, sums past 15, subtraction below zero) and the carry-hold behaviour of the logic operations reachable exhaustively rather than by sampling. The bench also drives a different word onto the input during decode and execute, to show that only the fetch edge captures it.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LD  = 3'b000,
        OP_ADD = 3'b001,
        OP_SUB = 3'b010,
        OP_INC = 3'b011,
        OP_DEC = 3'b100,
        OP_AND = 3'b101,
        OP_OR  = 3'b110,
        OP_XOR = 3'b111
    } opcode_e;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_LD,
        ST_ADD,
        ST_SUB,
        ST_INC,
        ST_DEC,
        ST_AND,
        ST_OR,
        ST_XOR
    } state_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_DEC,
        ALU_INC,
        ALU_AND,
        ALU_OR,
        ALU_NOT,
        ALU_XOR
    } alu_sel_e;

    typedef struct packed {
        logic     acc_we;
        logic     pass_imm;
        logic     cy_we;
        alu_sel_e sel;
    } exec_ctl_t;

    function automatic logic is_exec(state_e s);
        return (s != ST_FETCH) && (s != ST_DECODE);
    endfunction

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_sel_e          sel,
    output logic [DATA_W-1:0] y,
    output logic              cy
);
    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] ext;

    always_comb begin
        ext = '0;
        y   = '0;
        cy  = 1'b0;
        unique case (sel)
            ALU_ADD: begin
                ext = {1'b0, a} + {1'b0, b};
                y   = ext[DATA_W-1:0];
                cy  = ext[DATA_W];
            end
            ALU_SUB: begin
                ext = {1'b0, a} - {1'b0, b};
                y   = ext[DATA_W-1:0];
                cy  = ext[DATA_W];
            end
            ALU_INC: begin
                ext = {1'b0, a} + EXT_W'(1);
                y   = ext[DATA_W-1:0];
                cy  = ext[DATA_W];
            end
            ALU_DEC: begin
                ext = {1'b0, a} - EXT_W'(1);
                y   = ext[DATA_W-1:0];
                cy  = ext[DATA_W];
            end
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_NOT: y = ~a;
            ALU_XOR: y = a ^ b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  opcode_e   op,
    output state_e    state,
    output logic      ir_load,
    output exec_ctl_t ctl
);
    state_e state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = ST_FETCH;
        unique case (state)
            ST_FETCH:  state_nx = ST_DECODE;
            ST_DECODE: begin
                unique case (op)
                    OP_LD:   state_nx = ST_LD;
                    OP_ADD:  state_nx = ST_ADD;
                    OP_SUB:  state_nx = ST_SUB;
                    OP_INC:  state_nx = ST_INC;
                    OP_DEC:  state_nx = ST_DEC;
                    OP_AND:  state_nx = ST_AND;
                    OP_OR:   state_nx = ST_OR;
                    OP_XOR:  state_nx = ST_XOR;
                    default: state_nx = ST_FETCH;
                endcase
            end
            default:   state_nx = ST_FETCH;
        endcase
    end

    assign ir_load = (state == ST_FETCH);

    always_comb begin
        ctl          = '0;
        ctl.acc_we   = is_exec(state);
        ctl.sel      = ALU_ADD;
        unique case (state)
            ST_LD:  ctl.pass_imm = 1'b1;
            ST_ADD: begin ctl.sel = ALU_ADD; ctl.cy_we = 1'b1; end
            ST_SUB: begin ctl.sel = ALU_SUB; ctl.cy_we = 1'b1; end
            ST_INC: begin ctl.sel = ALU_INC; ctl.cy_we = 1'b1; end
            ST_DEC: begin ctl.sel = ALU_DEC; ctl.cy_we = 1'b1; end
            ST_AND: ctl.sel = ALU_AND;
            ST_OR:  ctl.sel = ALU_OR;
            ST_XOR: ctl.sel = ALU_XOR;
            default: ctl.sel = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [OP_W+DATA_W-1:0] instr_in,
    output logic [DATA_W-1:0]      acc_out,
    output logic                   carry_out,
    output logic                   done
);
    localparam int INSTR_W = OP_W + DATA_W;

    logic [INSTR_W-1:0] ir_q;
    logic [DATA_W-1:0]  acc_q;
    logic               cy_q;
    logic               done_q;

    state_e             state;
    logic               ir_load;
    exec_ctl_t          ctl;
    opcode_e            op;
    logic [DATA_W-1:0]  imm;
    logic [DATA_W-1:0]  alu_y;
    logic               alu_cy;

    assign op  = opcode_e'(ir_q[INSTR_W-1 -: OP_W]);
    assign imm = ir_q[DATA_W-1:0];

    acc_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .state   (state),
        .ir_load (ir_load),
        .ctl     (ctl)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .a   (acc_q),
        .b   (imm),
        .sel (ctl.sel),
        .y   (alu_y),
        .cy  (alu_cy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q   <= '0;
            acc_q  <= '0;
            cy_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= ctl.acc_we;
            if (ir_load)    ir_q  <= instr_in;
            if (ctl.acc_we) acc_q <= ctl.pass_imm ? imm : alu_y;
            if (ctl.cy_we)  cy_q  <= alu_cy;
        end
    end

    assign acc_out   = acc_q;
    assign carry_out = cy_q;
    assign done      = done_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
    import acc_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input logic                   clk,
    input logic                   rst,
    input state_e                 state,
    input logic [OP_W+DATA_W-1:0] ir,
    input logic [DATA_W-1:0]      acc,
    input logic                   cy,
    input logic                   done
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_EXEC_RETURNS: assert property (@(posedge clk) disable iff (rst)
        is_exec(state) |=> (state == ST_FETCH) && done); // R10

    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |=> (state == ST_DECODE)); // R10

    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state != ST_FETCH) |=> $stable(ir)); // R2

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !is_exec(state) |=> ($stable(acc) && $stable(cy))); // R3

    AST_LOAD_IMM: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LD) |=> (acc == $past(ir[DATA_W-1:0]))); // R4

    AST_INC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INC) |=> (acc == DATA_W'($past(acc) + 1'b1))); // R7

    AST_LOGIC_CARRY: assert property (@(posedge clk) disable iff (rst)
        (state inside {ST_LD, ST_AND, ST_OR, ST_XOR}) |=> $stable(cy)); // R9
endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .state (state),
    .ir    (ir_q),
    .acc   (acc_q),
    .cy    (cy_q),
    .done  (done_q)
);

// File: tb/sim_acc_core.sv
module sim_acc_core;
    import acc_pkg::*;

    localparam int DW = 4;
    localparam int IW = OP_W + DW;
    localparam int MOD = 1 << DW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [IW-1:0] instr = '0;
    logic [DW-1:0] acc;
    logic          cy;
    logic          done;

    int checks = 0;
    int errors = 0;
    int m_acc  = 0;
    int m_cy   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    acc_core #(.DATA_W(DW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .instr_in  (instr),
        .acc_out   (acc),
        .carry_out (cy),
        .done      (done)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string op_req(int op);
        case (op)
            0: return "R4 load";
            1: return "R5 add";
            2: return "R6 subtract";
            3: return "R7 increment";
            4: return "R7 decrement";
            default: return "R8 logic";
        endcase
    endfunction

    function automatic void model(int op, int imm);
        case (op)
            0: m_acc = imm;
            1: begin m_cy = (m_acc + imm > MOD - 1); m_acc = (m_acc + imm) % MOD; end
            2: begin m_cy = (m_acc < imm); m_acc = (m_acc - imm + MOD) % MOD; end
            3: begin m_cy = (m_acc == MOD - 1); m_acc = (m_acc + 1) % MOD; end
            4: begin m_cy = (m_acc == 0); m_acc = (m_acc + MOD - 1) % MOD; end
            5: m_acc = m_acc & imm;
            6: m_acc = m_acc | imm;
            default: m_acc = m_acc ^ imm;
        endcase
    endfunction

    // Called at a negedge while the core sits in fetch.
    task automatic run(int op, int imm);
        logic [IW-1:0] word;
        string cy_req;
        word = IW'((op << DW) | (imm % MOD));
        cy_req = (op == 0 || op >= 5) ? "R9 carry held" : op_req(op);
        instr = word;
        @(posedge clk); @(negedge clk);
        instr = ~word; // R2: must be ignored after fetch
        chk("R10 done low in decode", int'(done), 0);
        chk("R3 acc held in decode", int'(acc), m_acc);
        @(posedge clk); @(negedge clk);
        instr = word ^ IW'(5);
        chk("R10 done low in execute", int'(done), 0);
        chk("R3 acc held in execute", int'(acc), m_acc);
        chk("R3 carry held in execute", int'(cy), m_cy);
        model(op, imm % MOD);
        @(posedge clk); @(negedge clk);
        chk("R10 done pulse", int'(done), 1);
        chk({op_req(op), " R2 result"}, int'(acc), m_acc);
        chk(cy_req, int'(cy), m_cy);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        instr = IW'(7'h5A);
        repeat (3) @(negedge clk);
        chk("R1 reset acc", int'(acc), 0);
        chk("R1 reset carry", int'(cy), 0);
        chk("R1 reset done", int'(done), 0);
        rst = 1'b0;

        run(0, 9);
        run(1, 9);    // 18 wraps to 2, carry
        run(2, 5);    // 2-5 borrows
        run(5, 0);    // carry must stay 1
        run(0, 15);
        run(3, 6);    // 15+1 wraps, low bits ignored
        run(4, 9);    // 0-1 borrows
        run(7, 10);
        run(6, 0);
        run(4, 0);
        run(3, 15);

        // R1: reset between instructions
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 mid-run reset acc", int'(acc), 0);
        chk("R1 mid-run reset carry", int'(cy), 0);
        chk("R1 mid-run reset done", int'(done), 0);
        rst = 1'b0;
        m_acc = 0;
        m_cy  = 0;
        run(3, 0);    // R1: fetch phase after reset, 0+1

        for (int op = 0; op < 8; op++) begin
            for (int v = 0; v < MOD; v++) begin
                run(0, (op * 7 + v * 3) % MOD);
                run(op, v);
            end
        end

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule